// File: doc/BRIEF.md
# Receive Address Filter and Frame Gate

This block makes the keep-or-drop decision for frames arriving at the receive side of an Ethernet MAC. The receive path gives it the 48-bit destination address and the frame length, either on the same cycle or on separate cycles. Once both have arrived, the block classifies the destination as broadcast, multicast or unicast, filters it against the programmed acceptance controls and the station address, and then checks the length against a programmable DMA size limit and the fixed 1518-byte standard limit. The decision comes out one cycle later as a single-cycle result pulse. The pulse carries the reason flags and the length that the descriptor logic should report.

Software programs five configuration words through a simple write strobe and reads them back through a combinational read port. The words are the acceptance control, the CAM entry enable, the upper and lower parts of the station address, and the size control. CRC generation and descriptor writeback belong to other blocks. This block only tells them whether the four CRC bytes count toward the reported length.

Top module: `rx_addr_gate`

## Requirements
- R1: A broadcast destination (all 48 bits set) passes the filter when complement mode (control bit 3) is set. Otherwise it passes only when broadcast accept (control bit 2) is set.
- R2: A multicast destination (bit 40 set, the low bit of byte 0, and not broadcast) passes when complement mode is set. Otherwise it passes only when multicast accept (control bit 1) is set.
- R3: A unicast destination passes whenever accept-all-unicast (control bit 0) is set. Otherwise it uses a hit, which needs three things: compare enable (control bit 4), CAM entry 0 enabled, and the destination equal to the station address. Complement mode inverts that hit.
- R4: Only bit 0 of the CAM enable word (select 1) is stored. Its other bits always read back as zero.
- R5: The station address is assembled from two words. Byte 0 (dst_addr[47:40]) through byte 3 come from bits 31:24, 23:16, 15:8 and 7:0 of the high word (select 2). Bytes 4 and 5 come from bits 31:24 and 23:16 of the low word (select 3).
- R6: A frame shorter than 14 bytes, or longer than 65531 bytes, is dropped with every flag clear, the seen flag included.
- R7: A frame that passes the filter is dropped with the overflow flag when its length plus 4 exceeds the maximum receive size. That size lives in bits 15:0 of the size word (select 4) and resets to 0x0800.
- R8: A frame that passes the filter and fits the DMA limit, but whose length plus 4 exceeds 1518, is handled according to long-packet enable (size word bit 16). With the bit clear, the frame is dropped with the too-long flag. With the bit set, it is accepted with the long tag.
- R9: The seen flag is set for every frame that passes the R6 length check, whether or not the filter then drops it.
- R10: An accepted frame reports length plus 4 when CRC strip (size word bit 17) is clear, and the bare length when it is set. Rejected frames report 0.
- R11: The result pulse is raised for exactly one cycle, one clock edge after the edge on which the later of address and length was presented. The two may arrive in either order. Between results, all result outputs are zero.
- R12: After reset, no result is pending, the control word, CAM enable and station address read as zero, and the size word reads 0x00000800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration word select for writes |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rsel | input | 3 | Configuration word select for reads |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| dst_valid | input | 1 | Destination address strobe |
| dst_addr | input | 48 | Destination address, byte 0 in bits 47:40 |
| len_valid | input | 1 | Frame length strobe |
| frm_len | input | 16 | Frame length in bytes, without CRC |
| res_valid | output | 1 | Result pulse |
| res_accept | output | 1 | Frame accepted |
| res_seen | output | 1 | Frame passed the header length check |
| res_ovf | output | 1 | Dropped, exceeds the DMA size limit |
| res_toolong | output | 1 | Dropped, exceeds the standard limit |
| res_longtag | output | 1 | Accepted long frame tag |
| res_len | output | 16 | Reported length of an accepted frame |

## Verification
A wrong half-captured state shows up in two ways. A stale address or length latch either makes a result pulse appear one frame early or pairs a frame with the previous frame's field, so the first split-arrival frame after the fault reports the wrong decision. Corrupted configuration state shows up through the read port at once, and in the next frame whose class depends on the corrupted bit. The bench therefore mixes arrival orders, and it places frames on each side of both length limits and of the filter-versus-size priority.

// File: rtl/rx_addr_gate.sv
module rx_addr_gate #(
  parameter int LEN_W     = 16,
  parameter int HDR_BYTES = 14,
  parameter int CRC_BYTES = 4,
  parameter int STD_MAX   = 1518,
  parameter int SIZE_RST  = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic [2:0]       cfg_rsel,
  output logic [31:0]      cfg_rdata,
  input  logic             dst_valid,
  input  logic [47:0]      dst_addr,
  input  logic             len_valid,
  input  logic [LEN_W-1:0] frm_len,
  output logic             res_valid,
  output logic             res_accept,
  output logic             res_seen,
  output logic             res_ovf,
  output logic             res_toolong,
  output logic             res_longtag,
  output logic [LEN_W-1:0] res_len
);

  localparam int LIM_W = LEN_W + 1;
  localparam logic [LIM_W-1:0] LEN_CEIL = LIM_W'((1 << LEN_W) - 1 - CRC_BYTES);
  localparam logic [LIM_W-1:0] HDR_MIN  = LIM_W'(HDR_BYTES);
  localparam logic [LIM_W-1:0] STD_LIM  = LIM_W'(STD_MAX);
  localparam logic [LIM_W-1:0] CRC_ADD  = LIM_W'(CRC_BYTES);

  logic acc_uni, acc_multi, acc_bcast, cmp_inv, cmp_en, cam0;
  logic [31:0] sta_hi;
  logic [15:0] sta_lo;
  logic [LEN_W-1:0] max_sz;
  logic long_en, strip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {cmp_en, cmp_inv, acc_bcast, acc_multi, acc_uni} <= '0;
      cam0    <= 1'b0;
      sta_hi  <= '0;
      sta_lo  <= '0;
      max_sz  <= LEN_W'(SIZE_RST);
      long_en <= 1'b0;
      strip   <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: {cmp_en, cmp_inv, acc_bcast, acc_multi, acc_uni} <= cfg_wdata[4:0];
        3'd1: cam0 <= cfg_wdata[0];
        3'd2: sta_hi <= cfg_wdata;
        3'd3: sta_lo <= cfg_wdata[31:16];
        3'd4: {strip, long_en, max_sz} <= cfg_wdata[LEN_W+1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_rsel)
      3'd0: cfg_rdata = {27'd0, cmp_en, cmp_inv, acc_bcast, acc_multi, acc_uni};
      3'd1: cfg_rdata = {31'd0, cam0};
      3'd2: cfg_rdata = sta_hi;
      3'd3: cfg_rdata = {sta_lo, 16'd0};
      3'd4: cfg_rdata = 32'({strip, long_en, max_sz});
      default: cfg_rdata = '0;
    endcase
  end

  logic have_dst, have_len;
  logic [47:0] dst_q;
  logic [LEN_W-1:0] len_q;

  wire [47:0]      eff_dst = dst_valid ? dst_addr : dst_q;
  wire [LEN_W-1:0] eff_len = len_valid ? frm_len : len_q;
  wire ready = (dst_valid | have_dst) & (len_valid | have_len);

  wire is_bc  = &eff_dst;
  wire is_mc  = eff_dst[40] & ~is_bc;
  wire uni_hit = cmp_en & cam0 & (eff_dst == {sta_hi, sta_lo});
  wire pass_filt = is_bc ? (cmp_inv | acc_bcast) :
                   is_mc ? (cmp_inv | acc_multi) :
                           (acc_uni | (uni_hit ^ cmp_inv));

  wire [LIM_W-1:0] len_w    = {1'b0, eff_len};
  wire [LIM_W-1:0] len_plus = len_w + CRC_ADD;
  wire len_ok   = (len_w >= HDR_MIN) && (len_w <= LEN_CEIL);
  wire over_dma = len_plus > {1'b0, max_sz};
  wire over_std = len_plus > STD_LIM;
  wire fits     = len_ok & pass_filt & ~over_dma;
  wire n_acc    = fits & (~over_std | long_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_dst <= 1'b0;
      have_len <= 1'b0;
      dst_q    <= '0;
      len_q    <= '0;
      res_valid <= 1'b0;
      res_accept <= 1'b0;
      res_seen <= 1'b0;
      res_ovf <= 1'b0;
      res_toolong <= 1'b0;
      res_longtag <= 1'b0;
      res_len <= '0;
    end else if (ready) begin
      have_dst    <= 1'b0;
      have_len    <= 1'b0;
      res_valid   <= 1'b1;
      res_accept  <= n_acc;
      res_seen    <= len_ok;
      res_ovf     <= len_ok & pass_filt & over_dma;
      res_toolong <= fits & over_std & ~long_en;
      res_longtag <= n_acc & over_std;
      res_len     <= n_acc ? (strip ? eff_len : len_plus[LEN_W-1:0]) : '0;
    end else begin
      res_valid <= 1'b0;
      res_accept <= 1'b0;
      res_seen <= 1'b0;
      res_ovf <= 1'b0;
      res_toolong <= 1'b0;
      res_longtag <= 1'b0;
      res_len <= '0;
      if (dst_valid) begin
        have_dst <= 1'b1;
        dst_q    <= dst_addr;
      end
      if (len_valid) begin
        have_len <= 1'b1;
        len_q    <= frm_len;
      end
    end
  end

  p_cam_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rsel == 3'd1) |-> (cfg_rdata[31:1] == 31'd0));

  p_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_seen) |-> (!res_accept && !res_ovf && !res_toolong && res_len == '0));

  p_one_reason_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones({res_accept, res_ovf, res_toolong}) <= 1));

  p_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_longtag |-> (res_accept && res_len > LEN_W'(STD_MAX - CRC_BYTES)));

  p_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept |-> (res_len >= LEN_W'(HDR_BYTES)));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !(res_accept || res_seen || res_ovf || res_toolong || res_longtag));

  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !dst_valid && !len_valid) |=> !res_valid);

endmodule

// File: tb/sim_rx_addr_gate.sv
`timescale 1ns/100ps
module sim_rx_addr_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic cfg_we = 0; logic [2:0] cfg_sel = 0; logic [31:0] cfg_wdata = 0;
  logic [2:0] cfg_rsel = 0; logic [31:0] cfg_rdata;
  logic dst_valid = 0; logic [47:0] dst_addr = 0;
  logic len_valid = 0; logic [15:0] frm_len = 0;
  logic res_valid, res_accept, res_seen, res_ovf, res_toolong, res_longtag;
  logic [15:0] res_len;

  rx_addr_gate u0 (.*);

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  logic [20:0] exp_q[$];
  string tag_q[$];

  bit s_uni, s_mc, s_bc, s_inv, s_cmp, s_cam, s_long, s_strip;
  logic [47:0] s_sta;
  int s_max;

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic set_ctl(input bit uni, mc, bc, inv, cmp);
    s_uni = uni; s_mc = mc; s_bc = bc; s_inv = inv; s_cmp = cmp;
    wr(3'd0, {27'd0, cmp, inv, bc, mc, uni});
  endtask

  task automatic set_size(input int mx, input bit lg, input bit st);
    s_max = mx; s_long = lg; s_strip = st;
    wr(3'd4, {14'd0, st, lg, 16'(mx)});
  endtask

  task automatic rd_check(input logic [2:0] sel, input logic [31:0] exp, input string tag);
    @(negedge clk); cfg_rsel = sel; #1;
    vectors++;
    if (cfg_rdata !== exp) begin
      miscompares++;
      $display("FAIL %s: read sel %0d got %h expected %h", tag, sel, cfg_rdata, exp);
    end
  endtask

  function automatic logic [20:0] model(input logic [47:0] d, input int len);
    bit pass, hit, acc;
    int tot;
    tot = len + 4;
    if (len < 14 || len > 65531) return '0;
    if (d == '1) pass = s_inv || s_bc;
    else if (d[40]) pass = s_inv || s_mc;
    else begin
      hit = s_cmp && s_cam && (d == s_sta);
      pass = s_uni || (s_inv ? !hit : hit);
    end
    if (!pass) return {1'b0, 1'b1, 19'd0};
    if (tot > s_max) return {1'b0, 1'b1, 1'b1, 18'd0};
    if (tot > 1518 && !s_long) return {1'b0, 1'b1, 1'b0, 1'b1, 17'd0};
    acc = 1;
    return {acc, 1'b1, 1'b0, 1'b0, (tot > 1518) ? 1'b1 : 1'b0, 16'(s_strip ? len : tot)};
  endfunction

  task automatic send(input logic [47:0] d, input int len, input int mode, input string tag);
    exp_q.push_back(model(d, len));
    tag_q.push_back(tag);
    if (mode == 0) begin
      @(negedge clk); dst_valid = 1; dst_addr = d; len_valid = 1; frm_len = 16'(len);
      @(negedge clk); dst_valid = 0; len_valid = 0;
    end else if (mode == 1) begin
      @(negedge clk); dst_valid = 1; dst_addr = d;
      @(negedge clk); dst_valid = 0; dst_addr = '0;
      @(negedge clk);
      @(negedge clk); len_valid = 1; frm_len = 16'(len);
      @(negedge clk); len_valid = 0; frm_len = '0;
    end else begin
      @(negedge clk); len_valid = 1; frm_len = 16'(len);
      @(negedge clk); len_valid = 0; frm_len = '0;
      @(negedge clk); dst_valid = 1; dst_addr = d;
      @(negedge clk); dst_valid = 0; dst_addr = '0;
    end
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      logic [20:0] got, exp;
      string t;
      got = {res_accept, res_seen, res_ovf, res_toolong, res_longtag, res_len};
      vectors++;
      if (exp_q.size() == 0) begin
        miscompares++;
        $display("FAIL R11: unexpected result %h, expected none", got);
      end else begin
        exp = exp_q.pop_front();
        t = tag_q.pop_front();
        if (got !== exp) begin
          miscompares++;
          $display("FAIL %s: got acc/seen/ovf/tl/tag/len %h expected %h", t, got, exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  localparam logic [47:0] STA = 48'h02_11_22_33_44_55;
  localparam logic [47:0] BC  = '1;
  localparam logic [47:0] MC  = 48'h01_00_5e_00_00_07;

  initial begin
    s_uni = 0; s_mc = 0; s_bc = 0; s_inv = 0; s_cmp = 0; s_cam = 0;
    s_long = 0; s_strip = 0; s_max = 2048; s_sta = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    vectors++;
    if (res_valid !== 1'b0) begin
      miscompares++;
      $display("FAIL R12: res_valid got %b expected 0", res_valid);
    end
    rd_check(3'd4, 32'h0000_0800, "R12");
    rd_check(3'd0, 32'h0, "R12");
    rd_check(3'd2, 32'h0, "R12");

    wr(3'd1, 32'hffff_ffff); s_cam = 1;
    rd_check(3'd1, 32'h1, "R4");
    wr(3'd2, 32'h0211_2233); wr(3'd3, 32'h4455_abcd); s_sta = STA;
    rd_check(3'd3, 32'h4455_0000, "R5");

    set_ctl(0, 0, 0, 0, 1);
    send(STA, 64, 0, "R3 R5 unicast hit");
    send(STA ^ 48'h1, 64, 1, "R3 R5 byte5 mismatch");
    send(STA ^ 48'h0200_0000_0000, 64, 2, "R3 R5 byte0 mismatch");
    send(BC, 64, 0, "R1 broadcast off");
    send(MC, 64, 0, "R2 multicast off");
    set_ctl(0, 1, 1, 0, 1);
    send(BC, 100, 1, "R1 broadcast on");
    send(MC, 100, 2, "R2 multicast on");
    wr(3'd1, 32'h0000_0002); s_cam = 0;
    rd_check(3'd1, 32'h0, "R4");
    send(STA, 64, 0, "R3 R4 cam off");
    set_ctl(1, 0, 0, 0, 0);
    send(48'h0a_0b_0c_0d_0e_0f, 64, 0, "R3 all unicast");
    wr(3'd1, 32'h1); s_cam = 1;
    set_ctl(0, 0, 0, 1, 1);
    send(STA, 64, 0, "R3 complement hit");
    send(48'h0a_0b_0c_0d_0e_0f, 64, 1, "R3 complement miss");
    send(BC, 64, 0, "R1 complement");
    send(MC, 64, 2, "R2 complement");

    set_ctl(0, 1, 1, 0, 1);
    send(BC, 13, 0, "R6 runt");
    send(BC, 14, 0, "R6 R9 header size");
    send(BC, 65532, 0, "R6 giant");
    send(BC, 65531, 0, "R7 R9 largest legal");
    send(BC, 2044, 0, "R8 at dma limit");
    send(BC, 2045, 1, "R7 over dma limit");
    send(BC, 1514, 0, "R8 at std limit");
    send(BC, 1515, 2, "R8 over std limit");
    set_ctl(0, 1, 0, 0, 1);
    send(BC, 3000, 0, "R9 filtered before size");
    set_size(2048, 1, 0);
    send(MC, 2044, 0, "R8 long accepted");
    send(MC, 1515, 1, "R8 R10 long tagged");
    set_size(100, 0, 1);
    send(MC, 96, 0, "R7 R10 strip at limit");
    send(MC, 97, 2, "R7 small limit");
    set_size(2048, 0, 0);
    send(MC, 60, 0, "R10 crc added");

    repeat (6) @(negedge clk);
    vectors++;
    if (exp_q.size() != 0) begin
      miscompares++;
      $display("FAIL R11: pending results got %0d expected 0", exp_q.size());
    end
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule